// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command front end of a banked NOR-style flash device. It watches single-cycle bus writes (address, data, strobe) and decodes the multi-write unlock sequences the host uses to switch a bank into identification (autoselect) mode or to load the burst configuration code. It also takes single-write suspend, resume and reset commands.

For each bank it keeps a mode: reading the array, autoselect, erase-suspended reading, or busy. The busy and failure indications come in from the embedded-algorithm controller, which is outside this block. A failure seen while a bank is busy pins that bank in the busy mode until a reset command names it. A write that breaks a sequence parks the decoder in an error state. While it is there, every write except the reset command is ignored.

The configuration code is taken from the upper address bits of the last write of its sequence, not from the data bus. The load is refused while any bank is busy. The synchronous-read enable is bit 7 of the latched code, and it stays low until a load has been accepted.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is held and after it is released, every bank reads mode 0 (read array), `cfg_code` equals the parameter `CFG_RST` (default 0x0F) and `sync_en` is 0.
- R2: The writes AAh to 555h, then 55h to 2AAh, then 90h to 555h put the bank selected by address bits 19:18 into mode 1 (autoselect). Only bits 11:0 are compared against 555h and 2AAh. Bank b's mode is on `bank_mode[2b+1:2b]`. The bank stays in mode 1 until F0h is written to an address in that bank. Writing F0h to another bank leaves it in mode 1.
- R3: The writes AAh to 555h, then 55h to 2AAh, then C0h to an address whose bits 11:0 are 555h latch address bits 19:12 into `cfg_code` after the third write.
- R4: A configuration load is ignored while any `bank_busy` bit is high or any bank is in mode 3.
- R5: A bank in mode 0 whose `bank_busy` bit is high goes to mode 3 (busy). It returns to mode 0 one cycle after the bit falls.
- R6: If `bank_fail` is high while a bank is in mode 3, that bank stays in mode 3 after `bank_busy` falls. It returns to mode 0 only when F0h is written to an address in that bank.
- R7: B0h written to a bank in mode 3 moves it to mode 2 (erase-suspend read). It stays there when `bank_busy` falls and when F0h is written to it. A write of 30h to it returns it to mode 3.
- R8: A write that does not fit the current sequence step puts the decoder in an error state, where every write other than F0h is ignored. In the first step, the valid writes are AAh to 555h, B0h, 30h and F0h. F0h at any address returns the decoder to its idle step.
- R9: `sync_en` equals bit 7 of `cfg_code` once a load has been accepted, and is 0 before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 20 | Write address; bits 19:18 select the bank |
| wr_data | input | 8 | Write data (command code) |
| bank_busy | input | 4 | Per-bank embedded operation running |
| bank_fail | input | 4 | Per-bank operation failure flag |
| bank_mode | output | 8 | Two-bit mode per bank |
| cfg_code | output | 8 | Latched configuration code |
| sync_en | output | 1 | Synchronous read mode enabled |

## Verification
The bench aims at the recovery paths.

- A decoder that left the error state on a fresh unlock would wrongly put a bank in autoselect after a bad write.
- A bank that forgot a failure would drop back to mode 0 as soon as busy fell.
- A reset command that ignored the bank bits would release autoselect or a failure in the wrong bank.
- A suspended bank that followed busy would lose the suspend when the controller paused.
- A configuration latch without the busy guard would change the code during an operation.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_AUTO = 2'd1,
    MODE_SUSP = 2'd2,
    MODE_BUSY = 2'd3
  } bank_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_UL1,
    SEQ_UL2,
    SEQ_ERR
  } seq_e;

  typedef struct packed {
    logic go_rst;
    logic go_auto;
    logic go_cfg;
    logic go_susp;
    logic go_res;
  } cmd_t;

  localparam logic [7:0]  D_UL1  = 8'hAA;
  localparam logic [7:0]  D_UL2  = 8'h55;
  localparam logic [7:0]  D_AUTO = 8'h90;
  localparam logic [7:0]  D_CFG  = 8'hC0;
  localparam logic [7:0]  D_RST  = 8'hF0;
  localparam logic [7:0]  D_SUSP = 8'hB0;
  localparam logic [7:0]  D_RES  = 8'h30;
  localparam logic [11:0] A_UL1  = 12'h555;
  localparam logic [11:0] A_UL2  = 12'h2AA;

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  data,
  input  logic [11:0] low,
  output cmd_t        cmd
);

  seq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    cmd     = '0;
    if (wr_en) begin
      if (data == D_RST) begin
        cmd.go_rst = 1'b1;
        state_d    = SEQ_IDLE;
      end else begin
        case (state_q)
          SEQ_IDLE: begin
            if (data == D_UL1 && low == A_UL1) state_d = SEQ_UL1;
            else if (data == D_SUSP)           cmd.go_susp = 1'b1;
            else if (data == D_RES)            cmd.go_res = 1'b1;
            else                               state_d = SEQ_ERR;
          end
          SEQ_UL1: begin
            if (data == D_UL2 && low == A_UL2) state_d = SEQ_UL2;
            else                               state_d = SEQ_ERR;
          end
          SEQ_UL2: begin
            if (low == A_UL1 && data == D_AUTO) begin
              cmd.go_auto = 1'b1;
              state_d     = SEQ_IDLE;
            end else if (low == A_UL1 && data == D_CFG) begin
              cmd.go_cfg = 1'b1;
              state_d    = SEQ_IDLE;
            end else begin
              state_d = SEQ_ERR;
            end
          end
          default: state_d = SEQ_ERR;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_ERR && !(wr_en && data == D_RST)) |=> state_q == SEQ_ERR);

  // R8
  rst_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && data == D_RST) |=> state_q == SEQ_IDLE);

endmodule

// File: rtl/fcd_cfg.sv
module fcd_cfg #(
  parameter int          CW       = 8,
  parameter int          SYNC_BIT = 7,
  parameter logic [CW-1:0] CFG_RST = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          blocked,
  input  logic [CW-1:0] code_in,
  output logic [CW-1:0] code,
  output logic          sync_en
);

  logic [CW-1:0] code_q, code_d;
  logic          written_q, written_d;
  logic          take;

  assign take = load && !blocked;

  always_comb begin
    code_d    = code_q;
    written_d = written_q;
    if (take) begin
      code_d    = code_in;
      written_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= CFG_RST;
      written_q <= 1'b0;
    end else begin
      code_q    <= code_d;
      written_q <= written_d;
    end
  end

  assign code    = code_q;
  assign sync_en = written_q && code_q[SYNC_BIT];

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> $stable(code_q));

  // R3
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !blocked) |=> code_q == $past(code_in));

endmodule

// File: rtl/fcd_bank.sv
module fcd_bank
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy_in,
  input  logic       fail_in,
  input  logic       rst_hit,
  input  logic       auto_hit,
  input  logic       susp_hit,
  input  logic       res_hit,
  output bank_mode_e mode
);

  bank_mode_e mode_q, mode_d;
  logic       stuck_q, stuck_d;

  always_comb begin
    mode_d  = mode_q;
    stuck_d = stuck_q;
    if (stuck_q) begin
      if (rst_hit) begin
        mode_d  = MODE_READ;
        stuck_d = 1'b0;
      end
    end else begin
      case (mode_q)
        MODE_READ: begin
          if (busy_in)       mode_d = MODE_BUSY;
          else if (auto_hit) mode_d = MODE_AUTO;
        end
        MODE_AUTO: if (rst_hit) mode_d = MODE_READ;
        MODE_SUSP: if (res_hit) mode_d = MODE_BUSY;
        default: begin
          if (fail_in)       stuck_d = 1'b1;
          else if (susp_hit) mode_d = MODE_SUSP;
          else if (!busy_in) mode_d = MODE_READ;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_READ;
      stuck_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      stuck_q <= stuck_d;
    end
  end

  assign mode = mode_q;

  // R5
  busy_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_READ && !stuck_q && busy_in) |=> mode_q == MODE_BUSY);

  // R6
  stuck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck_q && !rst_hit) |=> (mode_q == MODE_BUSY && stuck_q));

  // R2
  auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_AUTO && !rst_hit) |=> mode_q == MODE_AUTO);

  // R7
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SUSP && !res_hit) |=> mode_q == MODE_SUSP);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int            AW      = 20,
  parameter int            NB      = 4,
  parameter int            CW      = 8,
  parameter logic [CW-1:0] CFG_RST = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [NB-1:0]   bank_busy,
  input  logic [NB-1:0]   bank_fail,
  output logic [2*NB-1:0] bank_mode,
  output logic [CW-1:0]   cfg_code,
  output logic            sync_en
);

  localparam int BW = $clog2(NB);
  localparam int LW = AW - CW;

  logic [1:0]    rs_q;
  logic          rst_i;
  cmd_t          cmd;
  logic [BW-1:0] bank_idx;
  bank_mode_e    mode_w [NB];
  logic          busy_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign bank_idx = wr_addr[AW-1 -: BW];

  fcd_seq u_seq (
    .clk   (clk),
    .rst_n (rst_i),
    .wr_en (wr_en),
    .data  (wr_data),
    .low   (wr_addr[LW-1:0]),
    .cmd   (cmd)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic sel;
    assign sel = (bank_idx == BW'(g));
    fcd_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_i),
      .busy_in  (bank_busy[g]),
      .fail_in  (bank_fail[g]),
      .rst_hit  (cmd.go_rst && sel),
      .auto_hit (cmd.go_auto && sel),
      .susp_hit (cmd.go_susp && sel),
      .res_hit  (cmd.go_res && sel),
      .mode     (mode_w[g])
    );
    assign bank_mode[2*g +: 2] = mode_w[g];
  end

  always_comb begin
    busy_any = |bank_busy;
    for (int i = 0; i < NB; i++) begin
      if (mode_w[i] == MODE_BUSY) busy_any = 1'b1;
    end
  end

  fcd_cfg #(
    .CW       (CW),
    .SYNC_BIT (CW - 1),
    .CFG_RST  (CFG_RST)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_i),
    .load    (cmd.go_cfg),
    .blocked (busy_any),
    .code_in (wr_addr[AW-1 -: CW]),
    .code    (cfg_code),
    .sync_en (sync_en)
  );

endmodule

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [19:0] wr_addr;
  logic [7:0]  wr_data;
  logic [3:0]  bank_busy;
  logic [3:0]  bank_fail;
  logic [7:0]  bank_mode;
  logic [7:0]  cfg_code;
  logic        sync_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .bank_busy (bank_busy),
    .bank_fail (bank_fail),
    .bank_mode (bank_mode),
    .cfg_code  (cfg_code),
    .sync_en   (sync_en)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h00555, 8'hAA);
    wr(20'h002AA, 8'h55);
  endtask

  task automatic t_reset();
    chk("R1 mode in reset", bank_mode, 8'h00);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 mode", bank_mode, 8'h00);
    chk("R1 cfg default", cfg_code, 8'h0F);
    chk("R1 sync", {7'd0, sync_en}, 8'h00);
  endtask

  task automatic t_cfg();
    unlock();
    wr({8'h3C, 12'h555}, 8'hC0);
    chk("R3 cfg 3C", cfg_code, 8'h3C);
    chk("R9 sync low bit7=0", {7'd0, sync_en}, 8'h00);
    unlock();
    wr({8'hA5, 12'h555}, 8'hC0);
    chk("R3 cfg A5", cfg_code, 8'hA5);
    chk("R9 sync high", {7'd0, sync_en}, 8'h01);
  endtask

  task automatic t_cfg_blocked();
    bank_busy = 4'b0010;
    tick();
    chk("R5 bank1 busy", bank_mode, 8'h0C);
    unlock();
    wr({8'h11, 12'h555}, 8'hC0);
    chk("R4 cfg held", cfg_code, 8'hA5);
    bank_busy = 4'b0000;
    tick();
    chk("R5 bank1 back", bank_mode, 8'h00);
  endtask

  task automatic t_autosel();
    unlock();
    wr(20'h80555, 8'h90);
    chk("R2 bank2 auto", bank_mode, 8'h10);
    wr(20'h00000, 8'hF0);
    chk("R2 other bank reset", bank_mode, 8'h10);
    wr(20'h80000, 8'hF0);
    chk("R2 exit auto", bank_mode, 8'h00);
  endtask

  task automatic t_fail();
    bank_busy = 4'b1000;
    tick();
    bank_fail = 4'b1000;
    tick();
    bank_fail = 4'b0000;
    bank_busy = 4'b0000;
    tick();
    tick();
    chk("R6 stuck busy", bank_mode, 8'hC0);
    unlock();
    wr({8'h22, 12'h555}, 8'hC0);
    chk("R4 cfg held stuck", cfg_code, 8'hA5);
    wr(20'h40000, 8'hF0);
    chk("R6 wrong bank reset", bank_mode, 8'hC0);
    wr(20'hC0000, 8'hF0);
    chk("R6 released", bank_mode, 8'h00);
  endtask

  task automatic t_susp();
    bank_busy = 4'b0001;
    tick();
    wr(20'h00000, 8'hB0);
    chk("R7 suspended", bank_mode, 8'h02);
    bank_busy = 4'b0000;
    tick();
    chk("R7 hold on idle", bank_mode, 8'h02);
    wr(20'h00000, 8'hF0);
    chk("R7 hold on reset", bank_mode, 8'h02);
    bank_busy = 4'b0001;
    wr(20'h00000, 8'h30);
    chk("R7 resumed", bank_mode, 8'h03);
    bank_busy = 4'b0000;
    tick();
    chk("R5 done", bank_mode, 8'h00);
  endtask

  task automatic t_seq_err();
    wr(20'h00555, 8'h12);
    unlock();
    wr(20'h40555, 8'h90);
    chk("R8 error ignores unlock", bank_mode, 8'h00);
    wr(20'h00000, 8'hF0);
    unlock();
    wr(20'h40555, 8'h90);
    chk("R8 recovered", bank_mode, 8'h04);
    wr(20'h40000, 8'hF0);
    wr(20'h00555, 8'hAA);
    wr(20'h00123, 8'h55);
    wr({8'h77, 12'h555}, 8'hC0);
    chk("R8 bad second step", cfg_code, 8'hA5);
    wr(20'h00000, 8'hF0);
    unlock();
    wr({8'h5A, 12'h555}, 8'hC0);
    chk("R8 load after reset", cfg_code, 8'h5A);
    chk("R9 sync follows bit7", {7'd0, sync_en}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    bank_busy = '0; bank_fail = '0;
    repeat (3) tick();
    t_reset();
    t_cfg();
    t_cfg_blocked();
    t_autosel();
    t_fail();
    t_susp();
    t_seq_err();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule